// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps one 8-bit status record for each finished transmission that software needs to see. The transmitter pulses a completion event with four outcome flags: interrupt-on-success requested, jabber, underrun and maximum collisions. Each completion that either carried an error or asked for an interrupt becomes a record in a small store of parameterised depth. The host reads the current record from a status byte. Any host write to the status port discards that record and exposes the next one.

The block asserts a TX-complete interrupt request while any record is waiting. If a completion finds the store already full, its record is lost, and the loss is reported in the status byte itself. A jabber or underrun drives a halt output that holds the transmitter off until software issues a TX reset. The TX reset also empties the store and clears the loss indication. A parameter selects which record the host sees first: the oldest (the default) or the newest.

Top module: `txc_status_stack`

## Requirements
- R1: The status byte of a held record has bit 7 = 1 (complete), bit 6 = interrupt-on-success requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = record-lost flag, and bits 1 and 0 always 0.
- R2: A completion with none of the four flags set creates no record. A completion with any of the four flags set creates one record, visible on the cycle after the event.
- R3: With the default order parameter (NEWEST_FIRST = 0), records are presented oldest first. With NEWEST_FIRST = 1, they are presented newest first.
- R4: A cycle with `pop_wr` high removes the presented record. `pop_wr` on an empty store has no effect on any output.
- R5: After reset, and whenever the store is empty, the status byte reads 0x00.
- R6: `txc_irq` is high exactly while the store holds at least one record.
- R7: A recordable completion that arrives while the store holds DEPTH records, with no pop in the same cycle, is dropped. From the next cycle on, bit 2 reads 1 in every presented record until a TX reset.
- R8: A completion with jabber or underrun raises `tx_halt` on the next cycle, and it stays high until a TX reset. Maximum collisions alone does not raise it.
- R9: `tx_reset` empties the store, clears the record-lost flag and releases `tx_halt` on the next cycle. It takes priority over a completion or pop in the same cycle.
- R10: A recordable completion and a pop in the same cycle on a full store both take effect, and no record is lost.
- R11: DEPTH (default 4, at least 2) sets the capacity: exactly DEPTH records are held before a further completion is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done | input | 1 | One-cycle completion event from the transmitter |
| tx_irq_req | input | 1 | Completion requested an interrupt on success |
| tx_jabber | input | 1 | Completion ended in a jabber error |
| tx_underrun | input | 1 | Completion ended in an underrun |
| tx_maxcoll | input | 1 | Completion hit the collision limit |
| pop_wr | input | 1 | Host write strobe to the status port (pops) |
| tx_reset | input | 1 | Transmit reset command |
| status_byte | output | 8 | Presented record, or 0x00 when empty |
| txc_irq | output | 1 | TX-complete interrupt request |
| tx_halt | output | 1 | Transmitter blocked after a fatal error |

## Verification
The hardest situation to reach is the full store: a completion must arrive with no pop in the same cycle, or with a pop in the same cycle. After that, the lost-record bit has to be seen on records written both before and after the loss, in both presentation orders.

The stimulus fills the store with records whose flags are distinct, so that their order can be seen. It overruns the store by one record, then applies a simultaneous push and pop, and drains the store past empty. An oldest-first and a newest-first instance run side by side against one arithmetic model. A long pseudo-random run then mixes completions, pops and rare resets.

// File: rtl/txc_pkg.sv
package txc_pkg;
   localparam int unsigned STAT_W  = 8;
   localparam int unsigned BIT_CPL = 7;
   localparam int unsigned BIT_IRQ = 6;
   localparam int unsigned BIT_JAB = 5;
   localparam int unsigned BIT_UND = 4;
   localparam int unsigned BIT_MCL = 3;
   localparam int unsigned BIT_OVF = 2;

   typedef logic [STAT_W-1:0] txc_stat_t;

   typedef struct packed {
      logic irq_req;
      logic jabber;
      logic underrun;
      logic max_coll;
   } txc_flags_t;

   function automatic txc_stat_t txc_pack(input txc_flags_t f);
      txc_stat_t s;
      s          = '0;
      s[BIT_CPL] = 1'b1;
      s[BIT_IRQ] = f.irq_req;
      s[BIT_JAB] = f.jabber;
      s[BIT_UND] = f.underrun;
      s[BIT_MCL] = f.max_coll;
      return s;
   endfunction
endpackage

// File: rtl/txc_entry_fmt.sv
module txc_entry_fmt
   import txc_pkg::*;
(
   input  logic       done,
   input  txc_flags_t flags,
   output logic       record,
   output logic       fatal,
   output txc_stat_t  entry
);
   logic any_err;

   assign any_err = flags.jabber | flags.underrun | flags.max_coll;
   assign record  = done & (any_err | flags.irq_req);
   assign fatal   = done & (flags.jabber | flags.underrun);
   assign entry   = txc_pack(flags);
endmodule

// File: rtl/txc_store.sv
module txc_store
   import txc_pkg::*;
#(
   parameter int unsigned DEPTH        = 4,
   parameter bit          NEWEST_FIRST = 1'b0,
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  txc_stat_t     din,
   output txc_stat_t     dout,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full,
   output logic          drop
);
   logic          pop_ok;
   logic          push_ok;
   logic [CW-1:0] cnt_q;
   txc_stat_t     mem [DEPTH];

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CW'(DEPTH));
   assign count   = cnt_q;
   assign pop_ok  = pop & ~empty & ~clr;
   assign push_ok = push & ~clr & (~full | pop_ok);
   assign drop    = push & ~clr & full & ~pop_ok;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else begin
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   generate
      if (NEWEST_FIRST) begin : g_lifo
         logic [PW-1:0] top_idx;
         logic [PW-1:0] wr_idx;

         assign top_idx = PW'(cnt_q - CW'(1));
         assign wr_idx  = pop_ok ? top_idx : PW'(cnt_q);
         assign dout    = empty ? '0 : mem[top_idx];

         always_ff @(posedge clk) begin
            if (push_ok) mem[wr_idx] <= din;
         end
      end else begin : g_fifo
         logic [PW-1:0] rd_q;
         logic [PW-1:0] wr_q;

         function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
            return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
         endfunction

         assign dout = empty ? '0 : mem[rd_q];

         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               rd_q <= '0;
               wr_q <= '0;
            end else begin
               if (push_ok) wr_q <= nxt(wr_q);
               if (pop_ok)  rd_q <= nxt(rd_q);
            end
         end

         always_ff @(posedge clk) begin
            if (push_ok) mem[wr_q] <= din;
         end
      end
   endgenerate

   // R11: occupancy never exceeds the configured capacity
   p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   // R4: popping an empty store leaves it empty
   p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !clr) |=> empty);

   // R10: push with pop on a full store keeps it full
   p_full_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && pop && !clr) |=> full);
endmodule

// File: rtl/txc_halt_ctl.sv
module txc_halt_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic fatal_evt,
   input  logic ovf_evt,
   output logic halt,
   output logic ovf
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         halt <= 1'b0;
         ovf  <= 1'b0;
      end else begin
         if (fatal_evt) halt <= 1'b1;
         if (ovf_evt)   ovf  <= 1'b1;
      end
   end

   // R8: halt is sticky until a TX reset
   p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !clr) |=> halt);

   // R9: TX reset releases halt and clears the lost flag
   p_clr_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!halt && !ovf));

   // R7: the lost flag is sticky until a TX reset
   p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf);
endmodule

// File: rtl/txc_status_stack.sv
module txc_status_stack
   import txc_pkg::*;
#(
   parameter int unsigned DEPTH        = 4,
   parameter bit          NEWEST_FIRST = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_done,
   input  logic       tx_irq_req,
   input  logic       tx_jabber,
   input  logic       tx_underrun,
   input  logic       tx_maxcoll,
   input  logic       pop_wr,
   input  logic       tx_reset,
   output logic [7:0] status_byte,
   output logic       txc_irq,
   output logic       tx_halt
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("txc_status_stack: DEPTH must be at least 2");
      end
   endgenerate

   txc_flags_t    flags;
   logic          record;
   logic          fatal;
   txc_stat_t     entry;
   txc_stat_t     top;
   logic [CW-1:0] count;
   logic          empty;
   logic          full;
   logic          drop;
   logic          ovf;

   assign flags = '{irq_req: tx_irq_req, jabber: tx_jabber,
                    underrun: tx_underrun, max_coll: tx_maxcoll};

   txc_entry_fmt u_fmt (
      .done   (tx_done),
      .flags  (flags),
      .record (record),
      .fatal  (fatal),
      .entry  (entry)
   );

   txc_store #(.DEPTH(DEPTH), .NEWEST_FIRST(NEWEST_FIRST)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tx_reset),
      .push  (record),
      .pop   (pop_wr),
      .din   (entry),
      .dout  (top),
      .count (count),
      .empty (empty),
      .full  (full),
      .drop  (drop)
   );

   txc_halt_ctl u_halt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (tx_reset),
      .fatal_evt (fatal),
      .ovf_evt   (drop),
      .halt      (tx_halt),
      .ovf       (ovf)
   );

   always_comb begin
      status_byte = top;
      if (!empty) status_byte[BIT_OVF] = top[BIT_OVF] | ovf;
   end

   assign txc_irq = ~empty;

   // R5: empty store presents zero
   p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> (status_byte == 8'h00));

   // R1: a held record always shows complete and zero low bits
   p_cpl_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      txc_irq |-> (status_byte[BIT_CPL] && status_byte[1:0] == 2'b00));

   // R7: a completion into a full store with no pop sets the lost flag
   p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && record && !pop_wr && !tx_reset) |=> (status_byte[BIT_OVF] && txc_irq));

   // R8: a fatal completion halts the transmitter on the next cycle
   p_fatal_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && (tx_jabber || tx_underrun) && !tx_reset) |=> tx_halt);

   // R2: a recordable completion leaves at least one record
   p_record_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (record && !tx_reset) |=> txc_irq);
endmodule

// File: tb/txc_status_stack_tb.sv
module txc_status_stack_tb;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int DEPTH = 4;

   logic clk = 1'b0;
   logic rst_n;
   logic tx_done, tx_irq_req, tx_jabber, tx_underrun, tx_maxcoll, pop_wr, tx_reset;
   logic [7:0] st_f, st_l;
   logic irq_f, irq_l, halt_f, halt_l;

   int checks = 0;
   int errors = 0;

   logic [7:0] fa [DEPTH];
   logic [7:0] la [DEPTH];
   int  mcnt;
   bit  movf, mhalt;

   always #5 clk = ~clk;

   txc_status_stack #(.DEPTH(DEPTH), .NEWEST_FIRST(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .tx_irq_req(tx_irq_req),
      .tx_jabber(tx_jabber), .tx_underrun(tx_underrun), .tx_maxcoll(tx_maxcoll),
      .pop_wr(pop_wr), .tx_reset(tx_reset),
      .status_byte(st_f), .txc_irq(irq_f), .tx_halt(halt_f));

   txc_status_stack #(.DEPTH(DEPTH), .NEWEST_FIRST(1'b1)) u_dut_lifo (
      .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .tx_irq_req(tx_irq_req),
      .tx_jabber(tx_jabber), .tx_underrun(tx_underrun), .tx_maxcoll(tx_maxcoll),
      .pop_wr(pop_wr), .tx_reset(tx_reset),
      .status_byte(st_l), .txc_irq(irq_l), .tx_halt(halt_l));

   task automatic chk(input string tag, input string what,
                      input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s actual %02h expected %02h", tag, what, got, exp);
      end
   endtask

   task automatic compare(input string tag);
      logic [7:0] ef, el, ob;
      ob = movf ? 8'h04 : 8'h00;
      ef = (mcnt == 0) ? 8'h00 : (fa[0] | ob);
      el = (mcnt == 0) ? 8'h00 : (la[mcnt-1] | ob);
      chk(tag, "oldest-first status", st_f, ef);
      chk(tag == "R3" ? "R3" : tag, "newest-first status", st_l, el);
      chk("R6", "irq", {7'd0, irq_f}, {7'd0, mcnt != 0});
      chk("R6", "irq newest-first", {7'd0, irq_l}, {7'd0, mcnt != 0});
      chk("R8", "halt", {7'd0, halt_f}, {7'd0, mhalt});
      chk("R8", "halt newest-first", {7'd0, halt_l}, {7'd0, mhalt});
   endtask

   // f = {irq_req, jabber, underrun, maxcoll}
   task automatic step(input bit d, input logic [3:0] f, input bit p,
                       input bit r, input string tag);
      logic [7:0] ent;
      tx_done = d;
      {tx_irq_req, tx_jabber, tx_underrun, tx_maxcoll} = f;
      pop_wr   = p;
      tx_reset = r;
      if (r) begin
         mcnt = 0; movf = 0; mhalt = 0;
      end else begin
         if (d && (f[2] || f[1])) mhalt = 1;
         if (p && mcnt > 0) begin
            for (int i = 0; i < DEPTH - 1; i++) fa[i] = fa[i+1];
            mcnt--;
         end
         if (d && f != 4'd0) begin
            ent = {1'b1, f, 3'b000};
            if (mcnt < DEPTH) begin
               fa[mcnt] = ent;
               la[mcnt] = ent;
               mcnt++;
            end else begin
               movf = 1;
            end
         end
      end
      @(posedge clk);
      #1;
      tx_done = 0; {tx_irq_req, tx_jabber, tx_underrun, tx_maxcoll} = 4'd0;
      pop_wr = 0; tx_reset = 0;
      compare(tag);
   endtask

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      rst_n = 0;
      tx_done = 0; {tx_irq_req, tx_jabber, tx_underrun, tx_maxcoll} = 4'd0;
      pop_wr = 0; tx_reset = 0;
      mcnt = 0; movf = 0; mhalt = 0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;
      compare("R5");

      // R1, R2: every flag combination, then pop and reset
      for (int f = 0; f < 16; f++) begin
         step(1, 4'(f), 0, 0, (f == 0) ? "R2" : "R1");
         step(0, 4'd0, 1, 0, "R4");
         step(0, 4'd0, 0, 1, "R9");
      end

      // R7, R11: fill to DEPTH and one more
      for (int k = 0; k <= DEPTH; k++) step(1, 4'(8 + k), 0, 0, "R7");
      // R10: push and pop together while full
      step(1, 4'b1001, 1, 0, "R10");
      // R3, R4: drain past empty, checking order
      for (int k = 0; k < DEPTH + 2; k++) step(0, 4'd0, 1, 0, "R3");
      step(0, 4'd0, 1, 0, "R4");
      // R9: reset beats a same-cycle completion
      step(1, 4'b0100, 0, 1, "R9");

      // R11: capacity boundary with irq-only records, R8 maxcoll alone no halt
      for (int k = 0; k < DEPTH; k++) step(1, 4'b1000, 0, 0, "R11");
      step(1, 4'b0001, 0, 0, "R11");
      step(0, 4'd0, 0, 1, "R9");
      step(1, 4'b0001, 0, 0, "R8");
      step(0, 4'd0, 1, 1, "R9");

      // R6: pseudo-random mix
      lfsr = 16'hACE1;
      for (int n = 0; n < 600; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0], lfsr[4:1], lfsr[5] & lfsr[6], lfsr[15:11] == 5'd0, "R6");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule